// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small fully associative cache of virtual-to-physical page translations. A lookup presents a virtual page number, the current address-space identifier (ASID) and the kind of access (read or write, user or supervisor). In the same cycle the block answers with one of three outcomes: hit (with the frame number), miss (the caller must fetch the translation from the page table), or protection fault. Entries carry an ASID, so translations of several processes can stay resident across context switches.

A fill port installs a new translation. The target is the lowest-numbered free entry. If no entry is free, a victim is chosen by least-recently-used ageing or by an 8-bit LFSR, and an input pin selects which. The lowest entries are reserved: they hold fixed identity translations that are always valid and shared by every ASID, so the code that handles a miss can never miss itself. Two invalidate inputs clear either every non-reserved entry or only those of one ASID.

The per-cycle update is a command with four named values, chosen by priority each cycle: `OP_KILL_ALL` (full invalidate), `OP_KILL_ASID` (selective invalidate), `OP_FILL` (install), and `OP_IDLE`. The block returns to the choice every cycle, with no multi-cycle sequence. A lookup can run beside any of them.

Top module: `asid_tlb`

## Requirements
- R1: When `lk_req` is high, the outputs answer in the same cycle. `lk_hit` is high when a valid entry matches both the page number and the ASID and the access is permitted. `lk_pfn` then carries that entry's frame number. If several entries match, the lowest index wins.
- R2: When `lk_req` is high and no entry matches, `lk_miss` is high and `lk_pfn` is 0. Exactly one of hit, miss and fault is high when `lk_req` is high. All three are low when `lk_req` is low.
- R3: After reset every non-reserved entry is invalid, so any lookup outside the reserved pages misses.
- R4: `kill_all` clears the valid bit of every non-reserved entry at the next clock edge.
- R5: An entry whose ASID differs from `lk_asid` does not match. `kill_asid_req` clears only the non-reserved entries whose ASID equals `kill_asid_val`.
- R6: A matching lookup with `lk_write`=1 on an entry whose writable bit is 0, or with `lk_user`=1 on an entry whose user bit is 0, raises `lk_fault` instead of `lk_hit`, and `lk_pfn` is 0.
- R7: A write hit sets the entry's dirty bit. `lk_dirty` reports the stored dirty bit on a hit, and a fill clears it.
- R8: Entries 0 to N_RSV-1 hold page i mapped to frame i. They match any ASID, are writable and supervisor-only, and are always valid. They are never victims and are never cleared by an invalidate.
- R9: A fill writes the lowest-index invalid non-reserved entry when one exists.
- R10: With `repl_random`=0 and no free entry, a fill evicts the least recently touched non-reserved entry. A fill touches its victim. A hit touches its entry, except in a fill cycle, where only the fill touches. After reset, higher indices count as older.
- R11: With `repl_random`=1 and no free entry, the victim is N_RSV + (L mod (N_ENT-N_RSV)), where L is the LFSR value before the edge. L resets to 8'h01 and updates every cycle as L <= {L[6:0], L[7]^L[5]^L[4]^L[3]}.
- R12: Update priority is `kill_all` > `kill_asid_req` > `fill_req`. A lower-priority request in the same cycle is dropped.
- R13: A lookup always sees the contents from before the edge. If a fill in the same cycle evicts the entry that the lookup hit, the fill wins and the new entry's dirty bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching translation |
| lk_fault | output | 1 | Matching translation forbids the access |
| lk_pfn | output | PFN_W | Frame number on hit, else 0 |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| fill_req | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_asid | input | ASID_W | ASID of the new entry |
| fill_writable | input | 1 | New entry permits writes |
| fill_user | input | 1 | New entry permits user access |
| repl_random | input | 1 | 1: LFSR victim, 0: LRU victim |
| kill_all | input | 1 | Invalidate all non-reserved entries |
| kill_asid_req | input | 1 | Invalidate entries of one ASID |
| kill_asid_val | input | ASID_W | ASID to invalidate |

## Verification
The collision that matters most is a lookup and a fill in the same cycle. The lookup must answer from the old contents, the LRU order must take only the fill's touch, and a victim that equals the hit entry must come out clean. The bench provokes this in a directed step: it fills a full array under LRU while a lookup hits the oldest entry. Random traffic then keeps both ports busy at once. A behavioural model holds a recency queue and a model LFSR, and every cycle it predicts the outputs and compares them. Because of this, a wrong victim or a wrong touch order shows up as a wrong hit or miss in a later cycle.

// File: rtl/tlbq_pkg.sv
package tlbq_pkg;
    typedef enum logic [1:0] {
        OP_IDLE,
        OP_FILL,
        OP_KILL_ALL,
        OP_KILL_ASID
    } tlb_op_e;

    typedef enum logic [1:0] {
        VS_FREE,
        VS_RAND,
        VS_LRU
    } vsel_e;
endpackage

// File: rtl/tlbq_store.sv
module tlbq_store
    import tlbq_pkg::*;
#(
    parameter int N   = 16,
    parameter int RSV = 2,
    parameter int VW  = 20,
    parameter int PW  = 20,
    parameter int AW  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tlb_op_e       op,
    input  logic [IW-1:0] wr_idx,
    input  logic [VW-1:0] wr_vpn,
    input  logic [PW-1:0] wr_pfn,
    input  logic [AW-1:0] wr_asid,
    input  logic          wr_wable,
    input  logic          wr_user,
    input  logic [AW-1:0] kill_asid,
    input  logic          mark_dirty,
    input  logic [IW-1:0] mark_idx,
    input  logic [VW-1:0] q_vpn,
    input  logic [AW-1:0] q_asid,
    output logic          hit_any,
    output logic [IW-1:0] hit_idx,
    output logic [PW-1:0] sel_pfn,
    output logic          sel_wable,
    output logic          sel_user,
    output logic          sel_dirty,
    output logic [N-1:0]  valid_vec
);
    logic [PW-1:0] pfn_a   [N];
    logic          wable_a [N];
    logic          user_a  [N];
    logic          dirty_a [N];
    logic [N-1:0]  match;

    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam logic [IW-1:0] IDX = IW'(i);
        if (i < RSV) begin : g_rsv
            localparam logic [VW-1:0] RVPN = VW'(i);
            logic r_d;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_d <= 1'b0;
                end else if (mark_dirty && mark_idx == IDX) begin
                    r_d <= 1'b1;
                end
            end
            assign valid_vec[i] = 1'b1;
            assign pfn_a[i]     = PW'(i);
            assign wable_a[i]   = 1'b1;
            assign user_a[i]    = 1'b0;
            assign dirty_a[i]   = r_d;
            assign match[i]     = (q_vpn == RVPN);
        end else begin : g_dyn
            logic          r_v, r_w, r_u, r_d;
            logic [VW-1:0] r_vpn;
            logic [PW-1:0] r_pfn;
            logic [AW-1:0] r_asid;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_v    <= 1'b0;
                    r_w    <= 1'b0;
                    r_u    <= 1'b0;
                    r_d    <= 1'b0;
                    r_vpn  <= '0;
                    r_pfn  <= '0;
                    r_asid <= '0;
                end else begin
                    if (mark_dirty && mark_idx == IDX) begin
                        r_d <= 1'b1;
                    end
                    unique case (op)
                        OP_FILL: begin
                            if (wr_idx == IDX) begin
                                r_v    <= 1'b1;
                                r_w    <= wr_wable;
                                r_u    <= wr_user;
                                r_d    <= 1'b0;
                                r_vpn  <= wr_vpn;
                                r_pfn  <= wr_pfn;
                                r_asid <= wr_asid;
                            end
                        end
                        OP_KILL_ALL:  r_v <= 1'b0;
                        OP_KILL_ASID: begin
                            if (r_asid == kill_asid) r_v <= 1'b0;
                        end
                        OP_IDLE: ;
                    endcase
                end
            end
            assign valid_vec[i] = r_v;
            assign pfn_a[i]     = r_pfn;
            assign wable_a[i]   = r_w;
            assign user_a[i]    = r_u;
            assign dirty_a[i]   = r_d;
            assign match[i]     = r_v && (r_vpn == q_vpn) && (r_asid == q_asid);
        end
    end

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_any = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    assign sel_pfn   = pfn_a[hit_idx];
    assign sel_wable = wable_a[hit_idx];
    assign sel_user  = user_a[hit_idx];
    assign sel_dirty = dirty_a[hit_idx];

    // R4
    kill_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_KILL_ALL |=> valid_vec[N-1:RSV] == '0);

    // R9
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_FILL |=> valid_vec[$past(wr_idx)]);
endmodule

// File: rtl/tlbq_victim.sv
module tlbq_victim
    import tlbq_pkg::*;
#(
    parameter int N   = 16,
    parameter int RSV = 2,
    localparam int IW  = $clog2(N),
    localparam int NF  = N - RSV,
    localparam int AGW = $clog2(NF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  valid_vec,
    input  logic          use_rand,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim_idx
);
    localparam logic [IW-1:0]  RSV_I  = IW'(RSV);
    localparam logic [AGW-1:0] OLDEST = AGW'(NF - 1);

    logic [AGW-1:0] age_q [N];
    logic [7:0]     lfsr_q;
    logic           free_found;
    logic [IW-1:0]  free_idx, old_idx, rnd_idx;
    vsel_e          vsel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                age_q[i] <= (i < RSV) ? '0 : AGW'(i - RSV);
            end
        end else if (touch_en && touch_idx >= RSV_I) begin
            for (int i = RSV; i < N; i++) begin
                if (IW'(i) == touch_idx) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= 8'h01;
        end else begin
            lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
        end
    end

    always_comb begin
        free_found = 1'b0;
        free_idx   = RSV_I;
        for (int i = N - 1; i >= RSV; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
        old_idx = RSV_I;
        for (int i = RSV; i < N; i++) begin
            if (age_q[i] == OLDEST) old_idx = IW'(i);
        end
        rnd_idx = IW'(RSV + (int'(lfsr_q) % NF));
    end

    always_comb begin
        if (free_found)    vsel = VS_FREE;
        else if (use_rand) vsel = VS_RAND;
        else               vsel = VS_LRU;
    end

    always_comb begin
        unique case (vsel)
            VS_FREE: victim_idx = free_idx;
            VS_RAND: victim_idx = rnd_idx;
            VS_LRU:  victim_idx = old_idx;
            default: victim_idx = free_idx;
        endcase
    end

    // R8
    victim_not_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_idx >= RSV_I);

    // R9
    prefer_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec[N-1:RSV] != '1) |-> !valid_vec[victim_idx]);

    // R10
    touch_youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && touch_idx >= RSV_I) |=> age_q[$past(touch_idx)] == '0);

    // R11
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 8'h00);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlbq_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int N_RSV  = 2,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_dirty,
    input  logic              fill_req,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_writable,
    input  logic              fill_user,
    input  logic              repl_random,
    input  logic              kill_all,
    input  logic              kill_asid_req,
    input  logic [ASID_W-1:0] kill_asid_val
);
    localparam int IW = $clog2(N_ENT);

    tlb_op_e         op;
    logic            hit_any, sel_wable, sel_user, sel_dirty, viol;
    logic [IW-1:0]   hit_idx, victim, touch_idx;
    logic [PFN_W-1:0] sel_pfn;
    logic [N_ENT-1:0] valid_vec;
    logic            touch_en;

    always_comb begin
        if (kill_all)           op = OP_KILL_ALL;
        else if (kill_asid_req) op = OP_KILL_ASID;
        else if (fill_req)      op = OP_FILL;
        else                    op = OP_IDLE;
    end

    tlbq_store #(
        .N(N_ENT), .RSV(N_RSV), .VW(VPN_W), .PW(PFN_W), .AW(ASID_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .op(op),
        .wr_idx(victim), .wr_vpn(fill_vpn), .wr_pfn(fill_pfn),
        .wr_asid(fill_asid), .wr_wable(fill_writable), .wr_user(fill_user),
        .kill_asid(kill_asid_val),
        .mark_dirty(lk_hit & lk_write), .mark_idx(hit_idx),
        .q_vpn(lk_vpn), .q_asid(lk_asid),
        .hit_any(hit_any), .hit_idx(hit_idx), .sel_pfn(sel_pfn),
        .sel_wable(sel_wable), .sel_user(sel_user), .sel_dirty(sel_dirty),
        .valid_vec(valid_vec)
    );

    always_comb begin
        touch_en  = lk_hit;
        touch_idx = hit_idx;
        unique case (op)
            OP_FILL: begin
                touch_en  = 1'b1;
                touch_idx = victim;
            end
            OP_IDLE, OP_KILL_ALL, OP_KILL_ASID: ;
        endcase
    end

    tlbq_victim #(
        .N(N_ENT), .RSV(N_RSV)
    ) u_victim (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
        .use_rand(repl_random), .touch_en(touch_en),
        .touch_idx(touch_idx), .victim_idx(victim)
    );

    assign viol     = (lk_write & ~sel_wable) | (lk_user & ~sel_user);
    assign lk_hit   = lk_req & hit_any & ~viol;
    assign lk_fault = lk_req & hit_any & viol;
    assign lk_miss  = lk_req & ~hit_any;
    assign lk_pfn   = lk_hit ? sel_pfn : '0;
    assign lk_dirty = lk_hit & sel_dirty;

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit | lk_miss | lk_fault));

    // R6
    fault_no_pfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_pfn == '0);
endmodule

// File: tb/asid_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;
    localparam int N = 16, RSV = 2, NF = N - RSV;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_req = 0, lk_write = 0, lk_user = 0;
    logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_pfn = '0;
    logic [7:0] lk_asid = '0, fill_asid = '0, kill_asid_val = '0;
    logic fill_req = 0, fill_writable = 0, fill_user = 0;
    logic repl_random = 0, kill_all = 0, kill_asid_req = 0;
    logic lk_hit, lk_miss, lk_fault, lk_dirty;
    logic [19:0] lk_pfn;

    always #2 clk = ~clk;

    asid_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_asid(lk_asid), .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_pfn(lk_pfn), .lk_dirty(lk_dirty), .fill_req(fill_req),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_asid(fill_asid),
        .fill_writable(fill_writable), .fill_user(fill_user),
        .repl_random(repl_random), .kill_all(kill_all),
        .kill_asid_req(kill_asid_req), .kill_asid_val(kill_asid_val)
    );

    int total = 0, fails = 0;
    string tag = "R3";

    bit          m_val [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_pfn [N];
    logic [7:0]  m_asid [N];
    bit          m_wr [N], m_us [N], m_dir [N];
    int          lru[$];
    logic [7:0]  m_lfsr;

    function automatic void model_reset();
        lru.delete();
        for (int i = 0; i < N; i++) begin
            m_val[i] = (i < RSV); m_vpn[i] = 20'(i); m_pfn[i] = 20'(i);
            m_asid[i] = '0; m_wr[i] = (i < RSV); m_us[i] = 0; m_dir[i] = 0;
            if (i >= RSV) lru.push_back(i);
        end
        m_lfsr = 8'h01;
    endfunction

    function automatic void touch(int idx);
        if (idx < RSV) return;
        for (int k = 0; k < lru.size(); k++)
            if (lru[k] == idx) begin lru.delete(k); break; end
        lru.push_front(idx);
    endfunction

    task automatic idle_in();
        lk_req = 0; lk_write = 0; lk_user = 0;
        fill_req = 0; kill_all = 0; kill_asid_req = 0;
    endtask

    task automatic look(input logic [19:0] v, input logic [7:0] a, input bit w, input bit u);
        lk_req = 1; lk_vpn = v; lk_asid = a; lk_write = w; lk_user = u;
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [7:0] a,
                        input bit w, input bit u);
        fill_req = 1; fill_vpn = v; fill_pfn = p; fill_asid = a;
        fill_writable = w; fill_user = u;
    endtask

    task automatic cyc();
        bit eh, em, ef, ed; logic [19:0] ep; int mi, v;
        #1;
        eh = 0; em = 0; ef = 0; ed = 0; ep = '0; mi = -1;
        if (lk_req) begin
            for (int i = N - 1; i >= 0; i--)
                if (m_val[i] && m_vpn[i] == lk_vpn && (i < RSV || m_asid[i] == lk_asid)) mi = i;
            if (mi < 0) em = 1;
            else if ((lk_write && !m_wr[mi]) || (lk_user && !m_us[mi])) ef = 1;
            else begin eh = 1; ep = m_pfn[mi]; ed = m_dir[mi]; end
        end
        total++;
        if (lk_hit !== eh || lk_miss !== em || lk_fault !== ef || lk_pfn !== ep || lk_dirty !== ed) begin
            fails++;
            $display("FAIL %s t=%0t hit/miss/fault/pfn/dirty got %b %b %b %h %b exp %b %b %b %h %b",
                     tag, $time, lk_hit, lk_miss, lk_fault, lk_pfn, lk_dirty, eh, em, ef, ep, ed);
        end
        if (eh && lk_write) m_dir[mi] = 1;
        if (kill_all) begin
            for (int i = RSV; i < N; i++) m_val[i] = 0;
            if (eh) touch(mi);
        end else if (kill_asid_req) begin
            for (int i = RSV; i < N; i++) if (m_asid[i] == kill_asid_val) m_val[i] = 0;
            if (eh) touch(mi);
        end else if (fill_req) begin
            v = -1;
            for (int i = RSV; i < N; i++) if (!m_val[i] && v < 0) v = i;
            if (v < 0) v = repl_random ? RSV + (int'(m_lfsr) % NF) : lru[$];
            m_val[v] = 1; m_vpn[v] = fill_vpn; m_pfn[v] = fill_pfn; m_asid[v] = fill_asid;
            m_wr[v] = fill_writable; m_us[v] = fill_user; m_dir[v] = 0;
            touch(v);
        end else if (eh) begin
            touch(mi);
        end
        m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R3: idle and lookups after reset
        tag = "R3"; idle_in(); cyc();
        look(20'h5, 8'd1, 0, 0); cyc();
        look(20'h100, 8'd1, 0, 1); cyc();
        // R8: reserved identity entries, any ASID, supervisor only
        tag = "R8"; look(20'h0, 8'd7, 0, 0); cyc();
        look(20'h1, 8'd3, 1, 0); cyc();
        look(20'h1, 8'd3, 0, 1); cyc();
        // R9: fills land in lowest free entries
        tag = "R9"; idle_in();
        for (int k = 0; k < 4; k++) begin
            fill(20'h100 + 20'(k), 20'h200 + 20'(k), 8'd1, 1, 1); cyc();
        end
        idle_in();
        for (int k = 0; k < 4; k++) begin look(20'h100 + 20'(k), 8'd1, 0, 1); cyc(); end
        // R1: hit with frame
        tag = "R1"; look(20'h101, 8'd1, 0, 1); cyc();
        // R5: ASID mismatch misses
        tag = "R5"; look(20'h101, 8'd2, 0, 1); cyc();
        // R6: read-only write faults
        tag = "R6"; idle_in(); fill(20'h300, 20'h333, 8'd1, 0, 1); cyc();
        idle_in(); look(20'h300, 8'd1, 1, 1); cyc();
        look(20'h300, 8'd1, 0, 1); cyc();
        // R7: dirty bit
        tag = "R7"; look(20'h100, 8'd1, 1, 1); cyc();
        look(20'h100, 8'd1, 0, 1); cyc();
        look(20'h101, 8'd1, 0, 1); cyc();
        // R10: LRU eviction with touches
        tag = "R10"; repl_random = 0;
        for (int k = 0; k < 20; k++) begin
            idle_in(); fill(20'h400 + 20'(k), 20'h500 + 20'(k), 8'd1, 1, 1);
            if (k % 3 == 0) look(20'h100, 8'd1, 0, 1);
            cyc();
            idle_in(); look(20'h100, 8'd1, 0, 1); cyc();
        end
        idle_in();
        for (int k = 0; k < 20; k++) begin look(20'h400 + 20'(k), 8'd1, 0, 1); cyc(); end
        // R13: lookup hits the oldest entry while a fill evicts it
        tag = "R13";
        for (int k = 0; k < 6; k++) begin
            look(m_vpn[lru[$]], m_asid[lru[$]], 1, 1);
            fill(20'h600 + 20'(k), 20'h700 + 20'(k), 8'd1, 1, 1); cyc();
            idle_in(); look(20'h600 + 20'(k), 8'd1, 0, 1); cyc();
        end
        // R11: random replacement
        tag = "R11"; repl_random = 1;
        for (int k = 0; k < 24; k++) begin
            idle_in(); fill(20'h800 + 20'(k), 20'h900 + 20'(k), 8'd2, 1, 1); cyc();
        end
        idle_in();
        for (int k = 0; k < 24; k++) begin look(20'h800 + 20'(k), 8'd2, 0, 1); cyc(); end
        // R12: kill_all beats fill
        tag = "R12"; idle_in(); kill_all = 1; fill(20'hA00, 20'hA0A, 8'd2, 1, 1); cyc();
        idle_in(); look(20'hA00, 8'd2, 0, 1); cyc();
        // R4: full invalidate keeps reserved
        tag = "R4"; idle_in(); fill(20'hB00, 20'hB0B, 8'd3, 1, 1); cyc();
        idle_in(); kill_all = 1; cyc();
        idle_in(); look(20'hB00, 8'd3, 0, 1); cyc();
        look(20'h1, 8'd3, 0, 0); cyc();
        // R5: selective invalidate
        tag = "R5";
        for (int k = 0; k < 6; k++) begin
            idle_in(); fill(20'hC00 + 20'(k), 20'hD00 + 20'(k), 8'(1 + (k % 2)), 1, 1); cyc();
        end
        idle_in(); kill_asid_req = 1; kill_asid_val = 8'd1; fill(20'hE00, 20'hE0E, 8'd1, 1, 1); cyc();
        idle_in();
        for (int k = 0; k < 6; k++) begin look(20'hC00 + 20'(k), 8'(1 + (k % 2)), 0, 1); cyc(); end
        look(20'hE00, 8'd1, 0, 1); cyc();
        // R2: random concurrent traffic
        tag = "R2";
        for (int c = 0; c < 4000; c++) begin
            idle_in();
            if (c % 200 == 0) repl_random = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) != 0)
                look(($urandom_range(0, 5) == 0) ? 20'($urandom_range(0, 3)) : 20'h500 + 20'($urandom_range(0, 23)),
                     8'($urandom_range(1, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 2) == 0)
                fill(20'h500 + 20'($urandom_range(0, 23)), 20'($urandom), 8'($urandom_range(1, 3)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 99) == 0) kill_all = 1;
            if ($urandom_range(0, 49) == 0) begin
                kill_asid_req = 1; kill_asid_val = 8'($urandom_range(1, 3));
            end
            cyc();
        end
        idle_in();
        summary();
        $finish;
    end
endmodule